// File: doc/BRIEF.md
# Boundary-Gated Deferred Interrupt Unit

This unit stands between a small processor's interrupt sources and its sequencer. It sorts requests into two groups. Fast requests are serviced at any instruction boundary. Deferred requests are slower and are serviced only when the interpreter-dispatch instruction begins. The sequencer raises `insn_edge` at every ordinary instruction boundary and `disp_start` in the first cycle of the dispatch instruction. In that same cycle the unit answers with a one-cycle `take` pulse and a binary vector index, or with `disp_go`, which lets the dispatch run as normal.

Both groups latch every request level into a pending register, so a short pulse is held until it is serviced. The decision is combinational from the pending state, the live request lines and the strobes. A dispatch with nothing eligible therefore goes ahead in the cycle it starts and costs no extra cycle. Each deferred source has its own enable bit. A masked source keeps its pending bit but is passed over.

The vector space puts fast sources at indices 0 to NFAST-1 and deferred sources after them, at NFAST to NFAST+NDEF-1. Inside each group, a lower index has higher priority.

Top module: `dint_gate`

## Requirements
- R1: While `rst_n` is low, every pending bit is cleared. After reset, a `disp_start` with all deferred enables set and no request lines active gives `disp_go`=1 and `take`=0.
- R2: A deferred request is never taken at a cycle where only `insn_edge` is high. Deferred sources are examined only in a cycle where `disp_start` is high.
- R3: If `disp_start` is high and no fast source is active and no enabled deferred source is active, then `disp_go`=1 and `take`=0 in that same cycle.
- R4: If `disp_start` is high, no fast source is active, and at least one enabled deferred source is active, then `take`=1 and `disp_go`=0 in that cycle. `vec` equals NFAST plus the index of the lowest-numbered such deferred source.
- R5: A deferred source whose `slow_en` bit is 0 is never taken, but its pending bit is kept. It is taken at a later dispatch start once its enable bit is 1.
- R6: In any cycle where `insn_edge` or `disp_start` is high and some fast source is active, `take`=1 and `vec` equals the index (0 to NFAST-1) of the lowest-numbered active fast source. In that cycle `disp_go`=0, and any deferred request stays pending.
- R7: A request line that is high for one cycle sets its pending bit. The bit then stays set until that source is taken or reset is applied.
- R8: The pending bit of the source chosen by `take` is cleared at the clock edge that ends the `take` cycle. All other pending bits are kept.
- R9: A request line that is high in the same cycle as a strobe counts as active in that cycle.
- R10: `take` is high only in cycles where `insn_edge` or `disp_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_req | input | NFAST | Fast request lines, bit 0 highest priority |
| slow_req | input | NDEF | Deferred request lines, bit 0 highest priority |
| slow_en | input | NDEF | Per-source enable for deferred requests |
| insn_edge | input | 1 | Ordinary instruction boundary strobe |
| disp_start | input | 1 | First cycle of the dispatch instruction |
| take | output | 1 | Interrupt is taken this cycle |
| vec | output | VW | Binary index of the chosen source |
| disp_go | output | 1 | Dispatch proceeds normally this cycle |

## Verification
The bench builds the unit with NFAST=2 and NDEF=3, five sources in all. This small size lets it sweep every combination of fast requests, deferred requests and enable masks, under both the plain boundary strobe and the dispatch strobe. A second dispatch with all sources enabled then shows which pending bits survived the take and the masking. A separate sweep drives requests in the same cycle as the dispatch strobe, without prior latching.

// File: rtl/dint_gate.sv
module dint_gate #(
  parameter int NFAST = 4,
  parameter int NDEF  = 4,
  localparam int NTOT = NFAST + NDEF,
  localparam int VW   = (NTOT > 1) ? $clog2(NTOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFAST-1:0] fast_req,
  input  logic [NDEF-1:0]  slow_req,
  input  logic [NDEF-1:0]  slow_en,
  input  logic             insn_edge,
  input  logic             disp_start,
  output logic             take,
  output logic [VW-1:0]    vec,
  output logic             disp_go
);

  localparam logic [VW-1:0] FBASE = VW'(NFAST);

  logic [NTOT-1:0]  pend, live, cand, grant;
  logic [NFAST-1:0] fast_act;
  logic [NDEF-1:0]  slow_act;
  logic             fast_hit;

  assign live     = pend | {slow_req, fast_req};
  assign fast_act = live[NFAST-1:0];
  assign slow_act = live[NTOT-1:NFAST] & slow_en;
  assign fast_hit = (insn_edge | disp_start) & (|fast_act);

  assign cand = fast_hit   ? {{NDEF{1'b0}}, fast_act} :
                disp_start ? {slow_act, {NFAST{1'b0}}} : '0;

  always_comb begin
    vec = '0;
    for (int i = NTOT - 1; i >= 0; i--)
      if (cand[i]) vec = VW'(i);
  end

  assign take    = |cand;
  assign grant   = take ? (NTOT'(1) << vec) : '0;
  assign disp_go = disp_start & ~take;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= live & ~grant;
  end

  assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_edge && !disp_start && !(|fast_act)) |-> !take);
  assert_idle_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_start && !(|fast_act) && !(|slow_act)) |-> (disp_go && !take));
  assert_slow_on_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec >= FBASE) |-> (disp_start && !disp_go));
  assert_mask_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((grant[NTOT-1:NFAST] & ~slow_en) == '0));
  assert_fast_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_hit |-> (take && vec < FBASE && !disp_go));
  assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (($past(pend) & ~pend) == '0));
  assert_grant_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((pend & $past(grant)) == '0));
  assert_take_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (insn_edge || disp_start));

endmodule

// File: tb/dint_gate_test.sv
module dint_gate_test;
  localparam int NF = 2;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NF-1:0] fast_req;
  logic [ND-1:0] slow_req, slow_en;
  logic insn_edge, disp_start;
  logic take, disp_go;
  logic [2:0] vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dint_gate #(.NFAST(NF), .NDEF(ND)) uut (
    .clk(clk), .rst_n(rst_n), .fast_req(fast_req), .slow_req(slow_req),
    .slow_en(slow_en), .insn_edge(insn_edge), .disp_start(disp_start),
    .take(take), .vec(vec), .disp_go(disp_go));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {take, go, vec} from the requirements
  function automatic logic [4:0] model(input logic [4:0] pa, input logic [2:0] en,
                                       input bit bnd, input bit dsp);
    logic t = 1'b0;
    logic [2:0] v = 3'd0;
    if ((bnd || dsp) && pa[1:0] != 0) begin
      t = 1'b1; v = pa[0] ? 3'd0 : 3'd1;
    end else if (dsp && (pa[4:2] & en) != 0) begin
      t = 1'b1;
      for (int k = ND - 1; k >= 0; k--) if (pa[2+k] && en[k]) v = 3'(2 + k);
    end
    return {t, dsp & ~t, v};
  endfunction

  task automatic compare(input logic [4:0] e, input string req);
    chk(take == e[4], {req, " take"}, take, e[4]);
    chk(disp_go == e[3], {req, " disp_go"}, disp_go, e[3]);
    if (e[4]) chk(vec == e[2:0], {req, " vec"}, vec, e[2:0]);
  endtask

  task automatic drive(input logic [1:0] f, input logic [2:0] d, input logic [2:0] en,
                       input bit bnd, input bit dsp);
    fast_req = f; slow_req = d; slow_en = en; insn_edge = bnd; disp_start = dsp;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; drive(0, 0, 0, 0, 0);
    #1 chk(take == 0 && disp_go == 0, "R1 outputs in reset", take, 0);
    @(negedge clk);
    rst_n = 1'b1; drive(0, 0, 3'b111, 0, 1);
    #1 chk(disp_go == 1 && take == 0, "R1 empty after reset", disp_go, 1);
  endtask

  initial begin
    logic [4:0] pa, e;
    rst_n = 1'b0; drive(0, 0, 0, 0, 0);
    for (int f = 0; f < 4; f++)
      for (int d = 0; d < 8; d++)
        for (int en = 0; en < 8; en++)
          for (int kind = 0; kind < 2; kind++) begin
            do_reset();
            @(negedge clk);
            drive(2'(f), 3'(d), 3'(en), 0, 0);
            #1 chk(take == 0, "R10 no strobe no take", take, 0);
            @(negedge clk);
            drive(0, 0, 3'(en), kind == 0, kind == 1);
            pa = {3'(d), 2'(f)};
            e = model(pa, 3'(en), kind == 0, kind == 1);
            #1 compare(e, kind == 0 ? "R2/R6/R7 boundary" : "R4/R5/R6/R7 dispatch");
            if (e[4]) pa[e[2:0]] = 1'b0;
            @(negedge clk);
            drive(0, 0, 3'b111, 0, 1);
            e = model(pa, 3'b111, 0, 1);
            #1 compare(e, "R5/R8 later dispatch");
          end
    for (int d = 1; d < 8; d++) begin
      do_reset();
      @(negedge clk);
      drive(0, 3'(d), 3'b111, 0, 1);
      e = model({3'(d), 2'b00}, 3'b111, 0, 1);
      #1 compare(e, "R9 same-cycle deferred");
      @(negedge clk);
      drive(2'(d & 3), 3'(d), 3'b111, 1, 0);
      e = model({3'(d), 2'(d & 3)}, 3'b111, 1, 0);
      #1 compare(e, "R9 same-cycle fast");
    end
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule